// File: doc/BRIEF.md
# Control-Line System Test Initiator

This block runs the initiator side of a system test on a single shared open-drain control wire. A test can start in two ways. A host request starts it with a caller-supplied five-bit test code. A run of failed network startups starts it with the fixed stable-lock code. Once a test starts, the block takes the wire through a fixed sequence:

1. A sync pulse.
2. A short release.
3. Three identical test-start pulses.
4. The five code bits.
5. A quiet test pause.
6. A results window.

The results window has two slots for each node class: the first reports the node as alive and the second reports that it saw stable lock. The window always covers every class up to the configured maximum, so nodes that do not answer still occupy their slots.

During the class 1 slots the block drives its own alive and lock answers. It samples the wire in the middle of every result slot. When the sequence ends it raises a one-cycle done strobe and publishes active-high per-class alive and locked flags. These flags stay as they are until the next test completes.

Every duration is a parameter counted in clock ticks. A long real pause, such as 2.5 s, or result slots of 0.1 s each with a three-slot tail, is obtained by scaling the parameters.

Top module: `syst_initiator`

## Requirements
- R1: After reset the block releases the wire (`line_pull` = 0), and `busy`, `done`, `alive` and `locked` are all 0.
- R2: A `host_req` pulse while idle starts a test with `host_code`. The code bits go out `host_code[4]` first, then down to `host_code[0]`. Each bit lasts T_BIT ticks, with the wire pulled low for a 1 and released for a 0.
- R3: When the count of `startup_fail` pulses seen while idle reaches FAIL_LIMIT, the block starts a test with code 5'b00100. If `host_req` arrives in the same cycle, the host code is used instead. Starting any test clears the failure count.
- R4: The start sequence is: pulled low for T_SYNC, released for T_GAP, then three repetitions of pulled low for T_TSI_LO and released for T_TSI_HI.
- R5: After the code bits, the wire is released for T_PAUSE. Then come 2*MC result slots of T_SLOT each, in the order alive1, lock1, alive2, lock2 and so on. A released tail of T_TAIL follows.
- R6: In the class 1 alive slot the block pulls low exactly when `own_alive_n` is 0. In the class 1 lock slot it pulls low exactly when `own_lock_n` is 0. It releases the wire in every other result slot.
- R7: `alive[c]` is 1 exactly when the wire was low in the middle of the alive slot of class c+1. `locked[c]` follows the same rule for the lock slot. Classes with no responder read as 0.
- R8: `done` is a single-cycle pulse that comes exactly L ticks after the first pulled-low cycle of the test, where L is the total sequence length. `alive` and `locked` change only in that cycle.
- R9: While a test runs, `host_req` and `startup_fail` are ignored. The code in flight does not change, and the failure count does not advance.
- R10: `busy` is high from the first pulled-low cycle until the cycle of `done`, in which it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Single-cycle request to start a test |
| host_code | input | 5 | Test code for a host request, bit 4 sent first |
| startup_fail | input | 1 | Single-cycle pulse per failed network startup |
| own_alive_n | input | 1 | Initiator's own alive answer, low = alive |
| own_lock_n | input | 1 | Initiator's own lock answer, low = locked |
| line_in | input | 1 | Sensed wire level, 1 = released |
| line_pull | output | 1 | Open-drain enable, 1 pulls the wire low |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test strobe |
| alive | output | MC | Per-class alive flags, bit 0 = class 1 |
| locked | output | MC | Per-class stable-lock flags, bit 0 = class 1 |

## Verification
The assertions assume that `host_req` and `startup_fail` are single-cycle pulses. They also assume that each responder holds its level on the wire for the whole of its slot, so the mid-slot sample after the two-flop synchroniser sees a settled value.

The bench drives the responders slot-aligned from the test's first pulled-low cycle, keeping them steady across each slot. It raises requests only as one-cycle pulses, including deliberate ones during a running test. It changes the wire freely only between tests, where the flags must not move.

// File: rtl/syst_pkg.sv
package syst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_TSI,
    PH_PARAM,
    PH_PAUSE,
    PH_RESULT,
    PH_TAIL,
    PH_DONE
  } phase_e;

  localparam logic [4:0] STABLE_LOCK_CODE = 5'b00100;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int slot_bits(input int mc);
    return (2 * mc > 8) ? $clog2(2 * mc) : 3;
  endfunction

  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_SYNC:   return PH_TSI;
      PH_TSI:    return PH_PARAM;
      PH_PARAM:  return PH_PAUSE;
      PH_PAUSE:  return PH_RESULT;
      PH_RESULT: return PH_TAIL;
      PH_TAIL:   return PH_DONE;
      default:   return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/syst_launch.sv
module syst_launch
  import syst_pkg::*;
#(
  parameter int FAIL_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       host_req,
  input  logic [4:0] host_code,
  input  logic       startup_fail,
  output logic       start,
  output logic [4:0] code
);
  localparam int FW = $clog2(FAIL_LIMIT + 1);

  logic [FW-1:0] fail_cnt;
  logic          auto_hit;

  assign auto_hit = startup_fail && (fail_cnt == FW'(FAIL_LIMIT - 1));
  assign start    = !busy && (host_req || auto_hit);
  assign code     = host_req ? host_code : STABLE_LOCK_CODE;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_cnt <= '0;
    end else if (!busy) begin
      if (start)             fail_cnt <= '0;
      else if (startup_fail) fail_cnt <= fail_cnt + FW'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    fail_cnt < FW'(FAIL_LIMIT)); // R3
  AST_FAIL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(fail_cnt)); // R9

endmodule

// File: rtl/syst_sequencer.sv
module syst_sequencer
  import syst_pkg::*;
#(
  parameter int MC       = 8,
  parameter int T_SYNC   = 8,
  parameter int T_GAP    = 4,
  parameter int T_TSI_LO = 4,
  parameter int T_TSI_HI = 4,
  parameter int T_BIT    = 8,
  parameter int T_PAUSE  = 40,
  parameter int T_SLOT   = 16,
  parameter int T_TAIL   = 48,
  parameter int IW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [4:0]    code,
  input  logic          own_alive_n,
  input  logic          own_lock_n,
  output phase_e        phase,
  output logic [IW-1:0] slot,
  output logic          sample_en,
  output logic          line_pull
);
  localparam int DUR_MAX = max_int(max_int(max_int(T_SYNC, T_GAP), max_int(T_TSI_LO, T_TSI_HI)),
                                   max_int(max_int(T_BIT, T_PAUSE), max_int(T_SLOT, T_TAIL)));
  localparam int CW = $clog2(DUR_MAX + 1);

  logic [CW-1:0] tick;
  logic [IW-1:0] idx;
  logic [4:0]    code_r;
  logic [CW-1:0] dur;
  logic          last_idx;
  logic          pull_c;
  logic          tick_end;

  always_comb begin
    dur      = CW'(1);
    last_idx = 1'b1;
    pull_c   = 1'b0;
    case (phase)
      PH_SYNC: begin
        dur      = idx[0] ? CW'(T_GAP) : CW'(T_SYNC);
        last_idx = (idx == IW'(1));
        pull_c   = !idx[0];
      end
      PH_TSI: begin
        dur      = idx[0] ? CW'(T_TSI_HI) : CW'(T_TSI_LO);
        last_idx = (idx == IW'(5));
        pull_c   = !idx[0];
      end
      PH_PARAM: begin
        dur      = CW'(T_BIT);
        last_idx = (idx == IW'(4));
        pull_c   = code_r[3'd4 - idx[2:0]];
      end
      PH_PAUSE: dur = CW'(T_PAUSE);
      PH_RESULT: begin
        dur      = CW'(T_SLOT);
        last_idx = (idx == IW'(2 * MC - 1));
        pull_c   = ((idx == IW'(0)) && !own_alive_n) || ((idx == IW'(1)) && !own_lock_n);
      end
      PH_TAIL: dur = CW'(T_TAIL);
      default: ;
    endcase
  end

  assign tick_end  = (tick == dur - CW'(1));
  assign sample_en = (phase == PH_RESULT) && (tick == CW'(T_SLOT / 2));
  assign slot      = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      tick      <= '0;
      idx       <= '0;
      code_r    <= '0;
      line_pull <= 1'b0;
    end else begin
      line_pull <= pull_c;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_SYNC;
            code_r <= code;
            tick   <= '0;
            idx    <= '0;
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: begin
          if (tick_end) begin
            tick <= '0;
            if (last_idx) begin
              idx   <= '0;
              phase <= phase_after(phase);
            end else begin
              idx <= idx + IW'(1);
            end
          end else begin
            tick <= tick + CW'(1);
          end
        end
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |=> !line_pull); // R1
  AST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && phase != PH_DONE) |=> (phase != PH_IDLE)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !start) |=> (phase == PH_IDLE)); // R10
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> $stable(code_r)); // R9

endmodule

// File: rtl/syst_collect.sv
module syst_collect #(
  parameter int MC = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_in,
  input  logic          sample_en,
  input  logic [IW-1:0] slot,
  input  logic          finish,
  output logic          done,
  output logic [MC-1:0] alive,
  output logic [MC-1:0] locked
);
  logic          line_meta;
  logic          line_s;
  logic [MC-1:0] sh_alive;
  logic [MC-1:0] sh_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_meta <= 1'b1;
      line_s    <= 1'b1;
    end else begin
      line_meta <= line_in;
      line_s    <= line_meta;
    end
  end

  for (genvar c = 0; c < MC; c++) begin : g_cls
    logic a_q;
    logic l_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        a_q <= 1'b0;
        l_q <= 1'b0;
      end else if (sample_en && (slot[IW-1:1] == (IW-1)'(c))) begin
        if (!slot[0]) a_q <= !line_s;
        else          l_q <= !line_s;
      end
    end
    assign sh_alive[c] = a_q;
    assign sh_lock[c]  = l_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      alive  <= '0;
      locked <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        alive  <= sh_alive;
        locked <= sh_lock;
      end
    end
  end

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    !finish |=> ($stable(alive) && $stable(locked))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

endmodule

// File: rtl/syst_initiator.sv
module syst_initiator
  import syst_pkg::*;
#(
  parameter int MC         = 8,
  parameter int FAIL_LIMIT = 3,
  parameter int T_SYNC     = 8,
  parameter int T_GAP      = 4,
  parameter int T_TSI_LO   = 4,
  parameter int T_TSI_HI   = 4,
  parameter int T_BIT      = 8,
  parameter int T_PAUSE    = 40,
  parameter int T_SLOT     = 16,
  parameter int T_TAIL     = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic [4:0]    host_code,
  input  logic          startup_fail,
  input  logic          own_alive_n,
  input  logic          own_lock_n,
  input  logic          line_in,
  output logic          line_pull,
  output logic          busy,
  output logic          done,
  output logic [MC-1:0] alive,
  output logic [MC-1:0] locked
);
  localparam int IW = slot_bits(MC);

  logic          start;
  logic [4:0]    code;
  phase_e        phase;
  logic [IW-1:0] slot;
  logic          sample_en;

  assign busy = (phase != PH_IDLE);

  syst_launch #(.FAIL_LIMIT(FAIL_LIMIT)) u_launch (
    .clk(clk), .rst(rst), .busy(busy), .host_req(host_req), .host_code(host_code),
    .startup_fail(startup_fail), .start(start), .code(code)
  );

  syst_sequencer #(
    .MC(MC), .T_SYNC(T_SYNC), .T_GAP(T_GAP), .T_TSI_LO(T_TSI_LO), .T_TSI_HI(T_TSI_HI),
    .T_BIT(T_BIT), .T_PAUSE(T_PAUSE), .T_SLOT(T_SLOT), .T_TAIL(T_TAIL), .IW(IW)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .code(code), .own_alive_n(own_alive_n),
    .own_lock_n(own_lock_n), .phase(phase), .slot(slot), .sample_en(sample_en),
    .line_pull(line_pull)
  );

  syst_collect #(.MC(MC), .IW(IW)) u_collect (
    .clk(clk), .rst(rst), .line_in(line_in), .sample_en(sample_en), .slot(slot),
    .finish(phase == PH_DONE), .done(done), .alive(alive), .locked(locked)
  );

endmodule

// File: tb/syst_initiator_test.sv
module syst_initiator_test;
  localparam int MC = 8, FL = 3;
  localparam int TS = 8, TG = 4, TL = 4, TH = 4, TB = 8, TP = 40, SL = 16, TT = 48;
  localparam int B0 = TS, B1 = B0 + TG, B2 = B1 + 3 * (TL + TH), B3 = B2 + 5 * TB;
  localparam int B4 = B3 + TP, B5 = B4 + 2 * MC * SL, LEN = B5 + TT;

  logic clk = 0, rst = 1;
  logic host_req = 0, startup_fail = 0, own_alive_n = 1, own_lock_n = 1;
  logic [4:0] host_code = 0;
  logic node_pull = 0;
  logic line_in, line_pull, busy, done;
  logic [MC-1:0] alive, locked, na_g, nl_g;
  int checks = 0, failures = 0;

  assign line_in = !(line_pull || node_pull);
  always #5 clk = ~clk;

  syst_initiator uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_code(host_code),
    .startup_fail(startup_fail), .own_alive_n(own_alive_n), .own_lock_n(own_lock_n),
    .line_in(line_in), .line_pull(line_pull), .busy(busy), .done(done),
    .alive(alive), .locked(locked)
  );

  task automatic check(input string tag, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_pull(int k, logic [4:0] c, logic oa, logic ol);
    if (k < B0) return 1;
    if (k < B1) return 0;
    if (k < B2) return ((k - B1) % (TL + TH)) < TL;
    if (k < B3) return c[4 - (k - B2) / TB];
    if (k < B4) return 0;
    if (k < B5) begin
      int s = (k - B4) / SL;
      return (s == 0) ? !oa : (s == 1) ? !ol : 1'b0;
    end
    return 0;
  endfunction

  function automatic bit node_fn(int k);
    if (k < B4 || k >= B5) return 0;
    begin
      int s = (k - B4) / SL;
      int c = s / 2;
      if (c == 0) return 0;
      return (s % 2 == 0) ? !na_g[c] : !nl_g[c];
    end
  endfunction

  task automatic pulse_host(input logic [4:0] c);
    @(negedge clk); host_req = 1; host_code = c;
    @(negedge clk); host_req = 0;
  endtask

  task automatic pulse_fail();
    @(negedge clk); startup_fail = 1;
    @(negedge clk); startup_fail = 0;
  endtask

  task automatic run_test(input logic [4:0] c, input logic oa, input logic ol,
                          input logic [MC-1:0] na, input logic [MC-1:0] nl, input bit inject);
    int wait_n = 0, m2 = 0, m4 = 0, m5 = 0, m6 = 0, dn = 0, dbad = 0, bbad = 0;
    logic [MC-1:0] ea, el;
    logic [MC-1:0] ha, hl;
    own_alive_n = oa; own_lock_n = ol; na_g = na; nl_g = nl;
    while (!line_pull && wait_n < 100) begin @(negedge clk); wait_n++; end
    check("R2", line_pull, line_pull, 1, "test did not start");
    for (int k = 0; k <= LEN; k++) begin
      node_pull = node_fn(k);
      if (k < LEN && line_pull != exp_pull(k, c, oa, ol)) begin
        if (k < B2) m4++; else if (k < B3) m2++;
        else if (k >= B4 && k < B4 + 2 * SL) m6++; else m5++;
      end
      if (done) begin dn++; if (k != LEN) dbad++; end
      if (busy != (k < LEN)) bbad++;
      if (inject && k == 20) begin host_req = 1; host_code = ~c; startup_fail = 1; end
      if (inject && k == 21) begin host_req = 0; startup_fail = 0; end
      @(negedge clk);
    end
    node_pull = 0;
    check("R4", m4 == 0, m4, 0, "start sequence mismatch cycles");
    check(inject ? "R9" : "R2", m2 == 0, m2, 0, "code bit mismatch cycles");
    check("R5", m5 == 0, m5, 0, "pause/result/tail mismatch cycles");
    check("R6", m6 == 0, m6, 0, "own class 1 slot mismatch cycles");
    check("R8", dn == 1 && dbad == 0, dn, 1, "done pulses at offset LEN");
    check("R10", bbad == 0, bbad, 0, "busy mismatch cycles");
    ea = ~na; el = ~nl; ea[0] = !oa; el[0] = !ol;
    check("R7", alive == ea, alive, ea, "alive flags");
    check("R7", locked == el, locked, el, "locked flags");
    ha = alive; hl = locked;
    for (int i = 0; i < 30; i++) begin node_pull = $urandom_range(0, 1); @(negedge clk); end
    node_pull = 0;
    check("R8", alive == ha && locked == hl, {alive, locked}, {ha, hl}, "flags held between tests");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", {line_pull, busy, done} == 3'b000, {line_pull, busy, done}, 0, "reset outputs");
    check("R1", alive == 0 && locked == 0, {alive, locked}, 0, "reset flags");

    pulse_host(5'b00100);
    run_test(5'b00100, 0, 0, 8'b0000_0000, 8'b0000_0000, 0);
    pulse_host(5'b11111);
    run_test(5'b11111, 1, 1, 8'b1111_1111, 8'b1111_1111, 0);
    for (int t = 0; t < 3; t++) begin
      logic [4:0] c = 5'($urandom);
      logic [MC-1:0] na = MC'($urandom), nl = MC'($urandom);
      logic oa = 1'($urandom), ol = 1'($urandom);
      pulse_host(c);
      run_test(c, oa, ol, na, nl, 0);
    end

    pulse_host(5'b10001);
    run_test(5'b10001, 0, 1, 8'b1010_0101, 8'b0110_0110, 1);
    for (int i = 0; i < FL - 1; i++) pulse_fail();
    repeat (3) @(negedge clk);
    check("R9", busy == 0, busy, 0, "failures during a test were counted");
    pulse_fail();
    run_test(5'b00100, 1, 0, 8'b0011_1100, 8'b1100_0011, 0);

    for (int i = 0; i < FL - 1; i++) pulse_fail();
    @(negedge clk); host_req = 1; host_code = 5'b11010; startup_fail = 1;
    @(negedge clk); host_req = 0; startup_fail = 0;
    run_test(5'b11010, 0, 0, 8'b0101_0101, 8'b1111_0000, 0);
    for (int i = 0; i < FL - 1; i++) pulse_fail();
    repeat (3) @(negedge clk);
    check("R3", busy == 0, busy, 0, "count not cleared by host start");
    pulse_fail();
    run_test(5'b00100, 1, 1, 8'b0000_1111, 8'b0000_1111, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule